// File: doc/BRIEF.md
# Global Memory Coalescing Unit

This block turns one group-wide global load or store into a transaction plan. A 16-lane group gives, for each lane, an active bit, a byte address and an access width of 4, 8 or 16 bytes. The unit merges the lane accesses into as few naturally aligned memory segments as it can. It lists those segments in ascending address order. For every lane it records which segment serves it and the lane's byte offset inside that segment. Data never passes through the block: a memory front end takes the plan and performs the transfers.

There are two merge policies, chosen per request. The relaxed policy allows any lane order and any gaps. Lanes are grouped by the 256-byte aligned window that contains the lowest remaining address. Each group gets the smallest aligned segment that covers it, so a misaligned footprint is widened to a larger segment. A footprint that crosses a window boundary is split. The strict policy gives a single segment only to a perfectly ordered, contiguous and aligned group. Any other pattern falls back to one 32-byte segment per lane.

The request port and the transaction port both use valid/ready. `req_ready` is high only while the unit is idle, and the request fields are sampled only in the cycle of acceptance. `txn_valid` never depends on `txn_ready`. While `txn_valid` is high and `txn_ready` is low, every transaction field is held. The lane map and the misalignment flags keep their value from the cycle after the final transaction is accepted until the next request is accepted.

Top module: `coal_unit`

## Requirements
- R1: After reset, and whenever no plan is in progress, `req_ready` is 1. It drops to 0 in the cycle after a request is accepted and stays 0 until the plan ends.
- R2: An active lane is illegal when its size code is 3 or its address is not a multiple of its width (code 0 = 4 B, 1 = 8 B, 2 = 16 B). An illegal lane is set in `lane_misal` and served by no transaction. Inactive lanes are neither flagged nor served, and the map entries of unserved lanes read 0.
- R3: `txn_seg` encodes the segment size as 32 << code (0 = 32 B, 1 = 64 B, 2 = 128 B, 3 = 256 B), and `txn_base` is always a multiple of that size.
- R4: In relaxed mode, each transaction serves every remaining legal lane whose address lies in the same 256-byte aligned window as the lowest remaining address. Its segment is the smallest aligned one that contains all of those lanes.
- R5: In relaxed mode, any permutation of lanes within one aligned segment yields a single transaction.
- R6: A misaligned group footprint is widened. Sixteen 4-byte lanes from 0x104 give one 128-byte transaction at 0x100, and from 0x078 one 256-byte transaction at 0x000.
- R7: A footprint that crosses a 256-byte boundary is split. Sixteen 4-byte lanes from 0x0F0 give a 32-byte transaction at 0x0E0 and then a 64-byte transaction at 0x100.
- R8: In strict mode, when all 16 lanes are legal and share one width w, lane i is at base + i·w, and base is a multiple of 16·w, one transaction of 16·w bytes at base is produced.
- R9: In strict mode, any other pattern produces one 32-byte transaction per legal lane. The order is ascending address, and equal addresses go lowest lane first.
- R10: Transactions come one per accepted handshake in ascending base order. `txn_last` is 1 on the final one only, and after it `txn_valid` stays low until a new request is accepted.
- R11: While `txn_valid` is 1 and `txn_ready` is 0, `txn_valid`, `txn_base`, `txn_seg` and `txn_last` hold their values into the next cycle.
- R12: After a plan ends, for each served lane, `map_txn` holds the 0-based ordinal of the transaction that served it and `map_off` holds the lane address minus that transaction's base. Both read 0 after reset.
- R13: A request with no legal lane produces no transaction, and `req_ready` returns to 1 two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_strict | input | 1 | 1 selects the strict merge policy |
| req_mask | input | LANES | Per-lane active bits |
| req_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| req_size | input | LANES*2 | Lane width codes, lane i at bits [2i +: 2] |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Consumer takes the transaction |
| txn_base | output | ADDR_W | Segment base address |
| txn_seg | output | 2 | Segment size code, 32 << code bytes |
| txn_last | output | 1 | Final transaction of the plan |
| lane_misal | output | LANES | Illegal active lanes of the last request |
| map_txn | output | LANES*4 | Per-lane transaction ordinal |
| map_off | output | LANES*8 | Per-lane byte offset in its segment |

## Verification
The hardest case to reach is a plan in which one request yields several clusters of different sizes. A typical example is a group that straddles a 256-byte window boundary at an unaligned position, with the consumer stalling between transactions. To reach it, the stimulus slides a contiguous group across two windows in 4-byte steps, for every width and both policies, so every straddle point and every widening case occurs. The consumer alternates between always-ready and a pseudo-random ready pattern. Scattered random groups with random masks and width codes then exercise duplicates, illegal lanes and strict-mode fallback.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int SZ_W = 2;

  typedef enum logic [SZ_W-1:0] {
    SZ_4B  = 2'd0,
    SZ_8B  = 2'd1,
    SZ_16B = 2'd2,
    SZ_BAD = 2'd3
  } lane_sz_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PLAN = 1'b1
  } plan_st_e;

  // log2 of the byte width selected by a lane size code
  function automatic int unsigned sz_lg(input logic [SZ_W-1:0] code);
    return 32'(code) + 32'd2;
  endfunction
endpackage

// File: rtl/coal_lane_check.sv
module coal_lane_check
  import coal_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32
) (
  input  logic [LANES-1:0]        act,
  input  logic [LANES*ADDR_W-1:0] addr,
  input  logic [LANES*SZ_W-1:0]   size,
  output logic [LANES-1:0]        legal,
  output logic [LANES-1:0]        misal,
  output logic                    unit_stride
);
  localparam int GRP_LG = $clog2(LANES);

  logic [ADDR_W-1:0] a0;
  logic [SZ_W-1:0]   s0;
  logic [LANES-1:0]  stride_ok;
  logic              base_ok;

  assign a0 = addr[ADDR_W-1:0];
  assign s0 = size[SZ_W-1:0];

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [ADDR_W-1:0] a;
      logic [SZ_W-1:0]   s;
      logic [ADDR_W-1:0] low_mask;
      logic [ADDR_W-1:0] want;

      assign a        = addr[g*ADDR_W +: ADDR_W];
      assign s        = size[g*SZ_W +: SZ_W];
      assign low_mask = ~({ADDR_W{1'b1}} << sz_lg(s));
      assign legal[g] = act[g] && (s != SZ_BAD) && ((a & low_mask) == '0);
      assign misal[g] = act[g] && !legal[g];
      // position lane g must hold in a perfectly ordered group
      assign want          = a0 + (ADDR_W'(g) << sz_lg(s0));
      assign stride_ok[g]  = (s == s0) && (a == want);
    end
  endgenerate

  assign base_ok     = (a0 & ~({ADDR_W{1'b1}} << (sz_lg(s0) + GRP_LG))) == '0;
  assign unit_stride = (&legal) && (&stride_ok) && base_ok;
endmodule

// File: rtl/coal_min_find.sv
module coal_min_find #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32
) (
  input  logic [LANES-1:0]         cand,
  input  logic [LANES*ADDR_W-1:0]  addr,
  output logic [ADDR_W-1:0]        min_addr,
  output logic [$clog2(LANES)-1:0] min_idx
);
  localparam int IDX_W = $clog2(LANES);

  logic found;

  // Strict less-than keeps the lowest lane index on equal addresses.
  always_comb begin
    found    = 1'b0;
    min_addr = '0;
    min_idx  = '0;
    for (int i = 0; i < LANES; i++) begin
      if (cand[i] && (!found || (addr[i*ADDR_W +: ADDR_W] < min_addr))) begin
        found    = 1'b1;
        min_addr = addr[i*ADDR_W +: ADDR_W];
        min_idx  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/coal_seg_fit.sv
module coal_seg_fit #(
  parameter int LANES      = 16,
  parameter int ADDR_W     = 32,
  parameter int MIN_SEG_LG = 5,
  parameter int MAX_SEG_LG = 8
) (
  input  logic [LANES-1:0]                              cand,
  input  logic [LANES*ADDR_W-1:0]                       addr,
  input  logic [ADDR_W-1:0]                             min_addr,
  input  logic [$clog2(LANES)-1:0]                      min_idx,
  input  logic                                          single,
  output logic [LANES-1:0]                              cluster,
  output logic [$clog2(MAX_SEG_LG-MIN_SEG_LG+1)-1:0]    seg_code,
  output logic [ADDR_W-1:0]                             seg_base,
  output logic [LANES*MAX_SEG_LG-1:0]                   off
);
  localparam int NUM_SEG = MAX_SEG_LG - MIN_SEG_LG + 1;
  localparam int SEG_W   = $clog2(NUM_SEG);

  // in_seg[k][g]: candidate lane g lies in the 2^(MIN_SEG_LG+k) aligned
  // segment that holds the lowest remaining address
  logic [NUM_SEG-1:0][LANES-1:0] in_seg;

  generate
    for (genvar k = 0; k < NUM_SEG; k++) begin : g_size
      for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign in_seg[k][g] = cand[g] &&
          ((addr[g*ADDR_W +: ADDR_W] >> (MIN_SEG_LG + k)) == (min_addr >> (MIN_SEG_LG + k)));
      end
    end
  endgenerate

  always_comb begin
    if (single) begin
      cluster  = LANES'(1) << min_idx;
      seg_code = '0;
    end else begin
      cluster  = in_seg[NUM_SEG-1];
      seg_code = SEG_W'(NUM_SEG - 1);
      // segments nest, so the last match walking downward is the smallest
      for (int k = NUM_SEG - 2; k >= 0; k--) begin
        if (in_seg[k] == in_seg[NUM_SEG-1]) seg_code = SEG_W'(k);
      end
    end
  end

  assign seg_base = min_addr & ({ADDR_W{1'b1}} << (MIN_SEG_LG + 32'(seg_code)));

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_off
      logic [ADDR_W-1:0] diff;
      assign diff = addr[g*ADDR_W +: ADDR_W] - seg_base;
      assign off[g*MAX_SEG_LG +: MAX_SEG_LG] = diff[MAX_SEG_LG-1:0];
    end
  endgenerate
endmodule

// File: rtl/coal_unit.sv
module coal_unit
  import coal_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int ADDR_W     = 32,
  parameter int MIN_SEG_LG = 5,
  parameter int MAX_SEG_LG = 8
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       req_valid,
  output logic                                       req_ready,
  input  logic                                       req_strict,
  input  logic [LANES-1:0]                           req_mask,
  input  logic [LANES*ADDR_W-1:0]                    req_addr,
  input  logic [LANES*SZ_W-1:0]                      req_size,
  output logic                                       txn_valid,
  input  logic                                       txn_ready,
  output logic [ADDR_W-1:0]                          txn_base,
  output logic [$clog2(MAX_SEG_LG-MIN_SEG_LG+1)-1:0] txn_seg,
  output logic                                       txn_last,
  output logic [LANES-1:0]                           lane_misal,
  output logic [LANES*$clog2(LANES)-1:0]             map_txn,
  output logic [LANES*MAX_SEG_LG-1:0]                map_off
);
  localparam int NUM_SEG = MAX_SEG_LG - MIN_SEG_LG + 1;
  localparam int SEG_W   = $clog2(NUM_SEG);
  localparam int IDX_W   = $clog2(LANES);
  localparam int OFF_W   = MAX_SEG_LG;

  plan_st_e                  st_q;
  logic [LANES-1:0]          pend_q;
  logic [LANES-1:0]          misal_q;
  logic                      split_q;
  logic [LANES*ADDR_W-1:0]   addr_q;
  logic [IDX_W-1:0]          cnt_q;
  logic [LANES*IDX_W-1:0]    map_txn_q;
  logic [LANES*OFF_W-1:0]    map_off_q;

  logic [LANES-1:0]          legal_c;
  logic [LANES-1:0]          misal_c;
  logic                      stride_c;
  logic [ADDR_W-1:0]         min_addr_c;
  logic [IDX_W-1:0]          min_idx_c;
  logic [LANES-1:0]          cluster_c;
  logic [SEG_W-1:0]          seg_c;
  logic [ADDR_W-1:0]         base_c;
  logic [LANES*OFF_W-1:0]    off_c;
  logic                      accept;
  logic                      fire;

  // legality and ordering of the incoming group
  coal_lane_check #(.LANES(LANES), .ADDR_W(ADDR_W)) u_check (
    .act         (req_mask),
    .addr        (req_addr),
    .size        (req_size),
    .legal       (legal_c),
    .misal       (misal_c),
    .unit_stride (stride_c)
  );

  // lowest address among lanes still waiting
  coal_min_find #(.LANES(LANES), .ADDR_W(ADDR_W)) u_min (
    .cand     (pend_q),
    .addr     (addr_q),
    .min_addr (min_addr_c),
    .min_idx  (min_idx_c)
  );

  // cluster and segment for the next transaction
  coal_seg_fit #(
    .LANES(LANES), .ADDR_W(ADDR_W),
    .MIN_SEG_LG(MIN_SEG_LG), .MAX_SEG_LG(MAX_SEG_LG)
  ) u_fit (
    .cand     (pend_q),
    .addr     (addr_q),
    .min_addr (min_addr_c),
    .min_idx  (min_idx_c),
    .single   (split_q),
    .cluster  (cluster_c),
    .seg_code (seg_c),
    .seg_base (base_c),
    .off      (off_c)
  );

  assign req_ready  = (st_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign txn_valid  = (st_q == ST_PLAN) && (pend_q != '0);
  assign txn_base   = base_c;
  assign txn_seg    = seg_c;
  assign txn_last   = (pend_q & ~cluster_c) == '0;
  assign fire       = txn_valid && txn_ready;
  assign lane_misal = misal_q;
  assign map_txn    = map_txn_q;
  assign map_off    = map_off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      pend_q    <= '0;
      misal_q   <= '0;
      split_q   <= 1'b0;
      addr_q    <= '0;
      cnt_q     <= '0;
      map_txn_q <= '0;
      map_off_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q      <= ST_PLAN;
            pend_q    <= legal_c;
            misal_q   <= misal_c;
            split_q   <= req_strict && !stride_c;
            addr_q    <= req_addr;
            cnt_q     <= '0;
            map_txn_q <= '0;
            map_off_q <= '0;
          end
        end
        ST_PLAN: begin
          if (pend_q == '0) begin
            st_q <= ST_IDLE;
          end else if (fire) begin
            pend_q <= pend_q & ~cluster_c;
            cnt_q  <= cnt_q + 1'b1;
            for (int i = 0; i < LANES; i++) begin
              if (cluster_c[i]) begin
                map_txn_q[i*IDX_W +: IDX_W] <= cnt_q;
                map_off_q[i*OFF_W +: OFF_W] <= off_c[i*OFF_W +: OFF_W];
              end
            end
            if (txn_last) st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // base of the previous transaction within the current plan
  logic [ADDR_W-1:0] prev_base_q;
  logic              have_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_base_q <= '0;
      have_prev_q <= 1'b0;
    end else if (accept) begin
      have_prev_q <= 1'b0;
    end else if (fire) begin
      prev_base_q <= txn_base;
      have_prev_q <= 1'b1;
    end
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  a_r3_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_base & ~({ADDR_W{1'b1}} << (MIN_SEG_LG + 32'(txn_seg)))) == '0));

  a_r4_cluster_pending: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (((cluster_c & pend_q) != '0) && ((cluster_c & ~pend_q) == '0)));

  a_r10_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && have_prev_q) |-> (txn_base >= prev_base_q));

  a_r10_quiet_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && txn_last) |=> !txn_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=>
      (txn_valid && $stable(txn_base) && $stable(txn_seg) && $stable(txn_last)));
endmodule

// File: tb/coal_unit_tb.sv
module coal_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 16;
  localparam int AW         = 32;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_strict = 1'b0;
  logic [LANES-1:0]  req_mask = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES*2-1:0]  req_size = '0;
  logic              txn_valid;
  logic              txn_ready = 1'b0;
  logic [AW-1:0]     txn_base;
  logic [1:0]        txn_seg;
  logic              txn_last;
  logic [LANES-1:0]  lane_misal;
  logic [LANES*4-1:0] map_txn;
  logic [LANES*8-1:0] map_off;

  always #(CLK_PERIOD/2) clk = ~clk;

  coal_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_strict(req_strict),
    .req_mask(req_mask), .req_addr(req_addr), .req_size(req_size),
    .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_base(txn_base),
    .txn_seg(txn_seg), .txn_last(txn_last),
    .lane_misal(lane_misal), .map_txn(map_txn), .map_off(map_off)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [AW-1:0]    s_addr [LANES];
  logic [1:0]       s_sz   [LANES];
  logic [LANES-1:0] s_mask;
  bit               s_strict;

  logic [AW-1:0]    e_base [LANES];
  int               e_seg  [LANES];
  int               e_map  [LANES];
  int               e_off  [LANES];
  int               e_cnt;
  logic [LANES-1:0] e_mis;

  logic [AW-1:0]    g_base [LANES];
  int               g_seg  [LANES];
  int               g_cnt;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] step_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // expected plan, derived from R2, R4, R8, R9, R12
  task automatic build_model();
    logic [LANES-1:0] legal, pend, cl;
    bit coal, fits;
    int m, k;
    logic [AW-1:0] base;
    for (int i = 0; i < LANES; i++) begin
      e_map[i] = 0;
      e_off[i] = 0;
      legal[i] = s_mask[i] && (s_sz[i] != 2'd3) && ((s_addr[i] % (32'd4 << s_sz[i])) == 0);
    end
    e_mis = s_mask & ~legal;
    coal = (&legal) && ((s_addr[0] % (32'd64 << s_sz[0])) == 0);
    for (int i = 0; i < LANES; i++)
      if (s_sz[i] != s_sz[0] || s_addr[i] != s_addr[0] + i * (32'd4 << s_sz[0])) coal = 0;
    pend = legal;
    e_cnt = 0;
    while (pend != '0) begin
      m = -1;
      for (int i = 0; i < LANES; i++)
        if (pend[i] && (m < 0 || s_addr[i] < s_addr[m])) m = i;
      cl = '0;
      if (s_strict && !coal) begin
        cl[m] = 1'b1;
        k = 5;
      end else begin
        for (int i = 0; i < LANES; i++)
          if (pend[i] && (s_addr[i] >> 8) == (s_addr[m] >> 8)) cl[i] = 1'b1;
        k = 8;
        for (int kk = 7; kk >= 5; kk--) begin
          fits = 1;
          for (int i = 0; i < LANES; i++)
            if (cl[i] && (s_addr[i] >> kk) != (s_addr[m] >> kk)) fits = 0;
          if (!fits) break;
          k = kk;
        end
      end
      base = s_addr[m] & ~((32'd1 << k) - 1);
      e_base[e_cnt] = base;
      e_seg[e_cnt]  = k - 5;
      for (int i = 0; i < LANES; i++)
        if (cl[i]) begin
          e_map[i] = e_cnt;
          e_off[i] = int'(s_addr[i] - base);
        end
      e_cnt++;
      pend = pend & ~cl;
    end
  endtask

  task automatic run_req(input string tag, input int rdy_mode);
    bit stall, rdy;
    logic [AW-1:0] sb;
    logic [1:0] sg;
    logic sl;
    int to;
    build_model();
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready while idle", req_ready, 1);
    for (int i = 0; i < LANES; i++) begin
      req_addr[i*AW +: AW] = s_addr[i];
      req_size[i*2 +: 2]   = s_sz[i];
    end
    req_mask   = s_mask;
    req_strict = s_strict;
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0, "R1 ready low after accept", req_ready, 0);
    g_cnt = 0;
    stall = 0;
    sb = '0; sg = '0; sl = 1'b0;
    to = 0;
    while (!req_ready && to < 300) begin
      if (stall)
        chk(txn_valid && txn_base == sb && txn_seg == sg && txn_last == sl,
            "R11 held under stall", {txn_valid, txn_base}, {1'b1, sb});
      if (txn_valid) begin
        rdy = (rdy_mode == 0) ? 1'b1 : (step_rand() & 16'h5) != 0;
        txn_ready = rdy;
        if (rdy) begin
          chk((txn_base % (32'd32 << txn_seg)) == 0, "R3 base aligned", txn_base, txn_seg);
          if (g_cnt < e_cnt) begin
            chk(txn_base == e_base[g_cnt], {tag, " base"}, txn_base, e_base[g_cnt]);
            chk(int'(txn_seg) == e_seg[g_cnt], {tag, " seg"}, txn_seg, e_seg[g_cnt]);
            chk(txn_last == (g_cnt == e_cnt - 1), "R10 last flag", txn_last, g_cnt == e_cnt - 1);
          end else begin
            chk(1'b0, "R10 extra transaction", g_cnt, e_cnt);
          end
          if (g_cnt < LANES) begin
            g_base[g_cnt] = txn_base;
            g_seg[g_cnt]  = int'(txn_seg);
          end
          g_cnt++;
          stall = 0;
        end else begin
          stall = 1;
          sb = txn_base; sg = txn_seg; sl = txn_last;
        end
      end else begin
        txn_ready = 1'b0;
        stall = 0;
      end
      @(negedge clk);
      to++;
    end
    txn_ready = 1'b0;
    chk(to < 300, "R1 plan finishes", to, 300);
    chk(g_cnt == e_cnt, "R10 transaction count", g_cnt, e_cnt);
    chk(txn_valid == 1'b0, "R10 quiet after plan", txn_valid, 0);
    chk(lane_misal == e_mis, "R2 misaligned flags", lane_misal, e_mis);
    for (int i = 0; i < LANES; i++) begin
      chk(int'(map_txn[i*4 +: 4]) == e_map[i], "R12 lane ordinal", map_txn[i*4 +: 4], e_map[i]);
      chk(int'(map_off[i*8 +: 8]) == e_off[i], "R12 lane offset", map_off[i*8 +: 8], e_off[i]);
    end
  endtask

  task automatic set_contig(input logic [AW-1:0] base, input logic [1:0] sz, input bit strict);
    for (int i = 0; i < LANES; i++) begin
      s_addr[i] = base + i * (32'd4 << sz);
      s_sz[i]   = sz;
    end
    s_mask   = '1;
    s_strict = strict;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 reset ready", req_ready, 1);
    chk(txn_valid === 1'b0, "R10 reset no txn", txn_valid, 0);
    chk(lane_misal == '0, "R2 reset flags", lane_misal, 0);
    chk(map_txn == '0 && map_off == '0, "R12 reset map", map_off, 0);

    // R6: widening of misaligned footprints
    set_contig(32'h104, 2'd0, 0);
    run_req("R6 widen", 0);
    chk(g_cnt == 1 && g_base[0] == 32'h100 && g_seg[0] == 2, "R6 0x104 to 128@0x100", g_base[0], 32'h100);
    set_contig(32'h078, 2'd0, 0);
    run_req("R6 widen", 1);
    chk(g_cnt == 1 && g_base[0] == 32'h000 && g_seg[0] == 3, "R6 0x078 to 256@0x000", g_seg[0], 3);

    // R7: straddling a 256-byte boundary
    set_contig(32'h0F0, 2'd0, 0);
    run_req("R7 split", 1);
    chk(g_cnt == 2, "R7 two transactions", g_cnt, 2);
    chk(g_base[0] == 32'h0E0 && g_seg[0] == 0, "R7 first 32@0x0E0", g_base[0], 32'h0E0);
    chk(g_base[1] == 32'h100 && g_seg[1] == 1, "R7 second 64@0x100", g_base[1], 32'h100);

    // R8: strict, perfectly ordered groups
    set_contig(32'h400, 2'd1, 1);
    run_req("R8 strict coalesced", 0);
    chk(g_cnt == 1 && g_base[0] == 32'h400 && g_seg[0] == 2, "R8 8B group one 128", g_seg[0], 2);
    set_contig(32'h800, 2'd2, 1);
    run_req("R8 strict coalesced", 1);
    chk(g_cnt == 1 && g_base[0] == 32'h800 && g_seg[0] == 3, "R8 16B group one 256", g_seg[0], 3);

    // R5 / R9: a permutation inside one 64-byte segment
    set_contig(32'h200, 2'd0, 0);
    for (int i = 0; i < LANES; i++) s_addr[i] = 32'h200 + ((i ^ 5) * 4);
    run_req("R5 relaxed permute", 1);
    chk(g_cnt == 1 && g_seg[0] == 1, "R5 one 64B transaction", g_cnt, 1);
    s_strict = 1;
    run_req("R9 strict permute", 1);
    chk(g_cnt == 16, "R9 one per lane", g_cnt, 16);

    // R9: duplicate addresses in strict mode
    set_contig(32'h300, 2'd0, 1);
    for (int i = 0; i < LANES; i++) s_addr[i] = 32'h300 + (i / 4) * 4;
    run_req("R9 strict duplicates", 1);
    chk(g_cnt == 16, "R9 duplicates each served", g_cnt, 16);

    // R13: no legal lane
    set_contig(32'h40, 2'd0, 0);
    s_mask = '0;
    run_req("R13 empty", 0);
    chk(g_cnt == 0, "R13 no transaction", g_cnt, 0);
    set_contig(32'h42, 2'd0, 1);
    run_req("R13 all misaligned", 0);
    chk(g_cnt == 0 && lane_misal == '1, "R13 misaligned only", lane_misal, 16'hFFFF);

    // R2: illegal size code on one lane, one inactive lane
    set_contig(32'h500, 2'd0, 0);
    s_sz[3] = 2'd3;
    s_mask[9] = 1'b0;
    run_req("R2 bad code", 1);
    chk(lane_misal == 16'h0008, "R2 only lane 3 flagged", lane_misal, 16'h0008);

    // sweep: sliding contiguous groups across two windows, every width, both policies
    for (int st = 0; st < 2; st++)
      for (int sz = 0; sz < 3; sz++)
        for (int b = 0; b < 32'h200; b += 4) begin
          set_contig(b, 2'(sz), bit'(st));
          run_req(st != 0 ? "R9 strict sweep" : "R4 relaxed sweep", (b >> 2) & 1);
        end

    // scattered random groups
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < LANES; i++) begin
        s_sz[i] = 2'(step_rand() % 4);
        if (s_sz[i] == 2'd3 && step_rand()[0]) s_sz[i] = 2'd0;
        s_addr[i] = {16'h0, step_rand()} & 32'h3FF;
        if (step_rand()[2:0] != 0) s_addr[i] = s_addr[i] & ~((32'd4 << s_sz[i]) - 1);
      end
      s_mask   = step_rand() | step_rand();
      s_strict = step_rand()[0];
      run_req(s_strict ? "R9 strict random" : "R4 relaxed random", n & 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule